// File: doc/BRIEF.md
# Bridge Fault Monitor with Switch-On Blanking

This block supervises an H-bridge of n-channel power switches. Each switch has a comparator that reports an excessive drain-to-source voltage. The monitor samples that report only while the switch is commanded on, and only after a blanking window that follows every change of that leg's drive. A hit on a high-side switch counts as a short to ground. A hit on a low-side switch counts as a short to battery. A report that the supply drain line is open is treated as a short to ground on every leg whose high side is on.

Bridge faults are held until the enable input `awake` goes low. Undervoltage, overvoltage and overtemperature flags are not held: they are passed straight through. All of these sources are ORed together. The result is cleaned by an agreement filter and then drives `fault`. Any filtered fault requests a coast of the bridge. When the fault line is held low from outside, motor and supply faults no longer request a coast; sleep and thermal faults still do.

The blanking window is normally two dead times long. It is only one dead time when the leg was idle (both gates off) for longer than `long_thr` clocks before the change.

Top module: `bridge_fault_monitor`

## Requirements
- R1: After power-up reset, `fault` and `status` are 0. While `awake` is 0, `coast` is 1 and every latched bridge fault clears on the next clock edge.
- R2: With a leg's high-side command at 1, its `cmp_hi` bit at 1 and the window expired, that leg's short-to-ground status bit is set. This is `status[leg]`.
- R3: With a leg's low-side command at 1, its `cmp_lo` bit at 1 and the window expired, that leg's short-to-battery status bit is set. This is `status[NLEG+leg]`.
- R4: A `leg_chg` strobe on a leg that was not idle for more than `long_thr` clocks blanks sampling for 2*`dead_len` clocks. The first latching edge comes 2*`dead_len`+1 edges after the strobe edge.
- R5: A strobe on a leg that was idle (both gates 0) for more than `long_thr` clocks blanks sampling for `dead_len` clocks. Latching can occur `dead_len`+1 edges after the strobe edge.
- R6: Latched bridge faults stay set while `awake` is 1, even after the comparator bit returns to 0.
- R7: `status[2*NLEG]` (undervoltage), `status[2*NLEG+1]` (overvoltage) and `status[2*NLEG+2]` (overtemperature) follow their inputs and are not held.
- R8: `fault` changes only after three consecutive clock samples of the combined raw fault agree. Shorter pulses leave it unchanged.
- R9: While `fault` is 1 and `ext_low` is 0, `coast` is 1.
- R10: While `ext_low` is 1 and `awake` is 1, a filtered fault raises `coast` only if `ot` is 1.
- R11: `drain_open` at 1 acts as a short to ground on every leg whose high-side command is 1.
- R12: A comparator bit of a switch that is not commanded on sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| awake | input | 1 | 1 = operate; 0 = sleep: coast and clear latched faults |
| hi_cmd | input | NLEG | High-side gate command per leg |
| lo_cmd | input | NLEG | Low-side gate command per leg |
| leg_chg | input | NLEG | One-cycle strobe per leg on a drive change |
| dead_len | input | DT_W | Dead time in clocks |
| long_thr | input | IDLE_W | Idle length, in clocks, beyond which an idle interval counts as long |
| cmp_hi | input | NLEG | High-side drain-source comparator per leg |
| cmp_lo | input | NLEG | Low-side drain-source comparator per leg |
| drain_open | input | 1 | Supply drain line open indication |
| uv | input | 1 | Supply undervoltage |
| ov | input | 1 | Supply overvoltage |
| ot | input | 1 | Overtemperature |
| ext_low | input | 1 | Fault line sensed held low from outside |
| fault | output | 1 | Filtered fault indication |
| coast | output | 1 | Request to switch all gates off |
| status | output | 2*NLEG+3 | Per-leg latched faults, then undervoltage, overvoltage, overtemperature |

## Verification
The bench checks both window lengths to the exact edge. It probes the cycle before latching is allowed and the cycle in which it first happens. A design that counted the wrong window, or sampled as the strobe arrived, would latch one or more edges early.

It drives comparator bits on legs that are not commanded on, and short pulses of supply flags. This catches a design that checks every switch, or that passes glitches through the filter.

It also holds the fault line low externally, with and without a thermal fault. A design with the test-mode gating wrong would either coast in test mode or fail to coast on overtemperature.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef struct packed {
    logic stg;
    logic stb;
  } leg_flt_t;
endpackage

// File: rtl/bfm_leg_blanker.sv
module bfm_leg_blanker
  import bfm_pkg::*;
#(
  parameter int DT_W   = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              hi_on,
  input  logic              lo_on,
  input  logic              chg,
  input  logic [DT_W-1:0]   dead_len,
  input  logic [IDLE_W-1:0] long_thr,
  input  logic              cmp_hi,
  input  logic              cmp_lo,
  input  logic              drain_open,
  output leg_flt_t          flt
);
  localparam int BW = DT_W + 1;

  logic [BW-1:0]     blank_q, blank_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  leg_flt_t          lat_q, lat_d;
  logic              leg_off, long_idle, armed;

  always_comb begin
    leg_off   = ~hi_on & ~lo_on;
    long_idle = idle_q > long_thr;
    armed     = (blank_q == '0) & ~chg;

    idle_d = idle_q;
    if (!leg_off)             idle_d = '0;
    else if (idle_q != '1)    idle_d = idle_q + 1'b1;

    blank_d = blank_q;
    if (chg)                  blank_d = long_idle ? {1'b0, dead_len} : {dead_len, 1'b0};
    else if (blank_q != '0)   blank_d = blank_q - 1'b1;

    lat_d = lat_q;
    if (!awake) begin
      lat_d = '0;
    end else begin
      if (armed && hi_on && (cmp_hi || drain_open)) lat_d.stg = 1'b1;
      if (armed && lo_on && cmp_lo)                 lat_d.stb = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      idle_q  <= '0;
      lat_q   <= '0;
    end else begin
      blank_q <= blank_d;
      idle_q  <= idle_d;
      lat_q   <= lat_d;
    end
  end

  assign flt = lat_q;
endmodule

// File: rtl/bfm_agree_filter.sv
module bfm_agree_filter #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [N-2:0] hist_q, hist_d;
  logic [N-1:0] window;
  logic         filt_q, filt_d;

  always_comb begin
    window = {hist_q, raw};
    hist_d = window[N-2:0];
    filt_d = filt_q;
    if (&window)       filt_d = 1'b1;
    else if (~|window) filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/bridge_fault_monitor.sv
module bridge_fault_monitor
  import bfm_pkg::*;
#(
  parameter int NLEG   = 2,
  parameter int DT_W   = 8,
  parameter int IDLE_W = 8,
  parameter int FILT_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic [NLEG-1:0]   hi_cmd,
  input  logic [NLEG-1:0]   lo_cmd,
  input  logic [NLEG-1:0]   leg_chg,
  input  logic [DT_W-1:0]   dead_len,
  input  logic [IDLE_W-1:0] long_thr,
  input  logic [NLEG-1:0]   cmp_hi,
  input  logic [NLEG-1:0]   cmp_lo,
  input  logic              drain_open,
  input  logic              uv,
  input  logic              ov,
  input  logic              ot,
  input  logic              ext_low,
  output logic              fault,
  output logic              coast,
  output logic [2*NLEG+2:0] status
);
  localparam int UV_IDX = 2 * NLEG;

  leg_flt_t        leg_flt [NLEG];
  logic [NLEG-1:0] stg_v, stb_v;
  logic            raw_any;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    bfm_leg_blanker #(.DT_W(DT_W), .IDLE_W(IDLE_W)) u_blank (
      .clk        (clk),
      .rst_n      (rst_n),
      .awake      (awake),
      .hi_on      (hi_cmd[g]),
      .lo_on      (lo_cmd[g]),
      .chg        (leg_chg[g]),
      .dead_len   (dead_len),
      .long_thr   (long_thr),
      .cmp_hi     (cmp_hi[g]),
      .cmp_lo     (cmp_lo[g]),
      .drain_open (drain_open),
      .flt        (leg_flt[g])
    );
    assign stg_v[g] = leg_flt[g].stg;
    assign stb_v[g] = leg_flt[g].stb;
  end

  assign raw_any = (|stg_v) | (|stb_v) | uv | ov | ot;

  bfm_agree_filter #(.N(FILT_N)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_any),
    .filt  (fault)
  );

  assign coast = ~awake | (fault & (~ext_low | ot));

  always_comb begin
    status                 = '0;
    status[NLEG-1:0]       = stg_v;
    status[2*NLEG-1:NLEG]  = stb_v;
    status[UV_IDX]         = uv;
    status[UV_IDX+1]       = ov;
    status[UV_IDX+2]       = ot;
  end
endmodule

// File: rtl/bfm_chk.sv
module bfm_chk #(
  parameter int NLEG = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awake,
  input logic [NLEG-1:0]   hi_cmd,
  input logic              ext_low,
  input logic              ot,
  input logic              raw_any,
  input logic              fault,
  input logic              coast,
  input logic [2*NLEG+2:0] status
);
  // R1
  sleep_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> coast);

  // R1
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (status[2*NLEG-1:0] == '0));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && $past(awake)) |->
      ((status[2*NLEG-1:0] & $past(status[2*NLEG-1:0])) == $past(status[2*NLEG-1:0])));

  // R8
  filter_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(raw_any) && $past(raw_any, 2)));

  // R9
  fault_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !ext_low) |-> coast);

  // R10
  therm_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && ot) |-> coast);

  // R12
  cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(hi_cmd[0]));
endmodule

bind bridge_fault_monitor bfm_chk #(.NLEG(NLEG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .awake   (awake),
  .hi_cmd  (hi_cmd),
  .ext_low (ext_low),
  .ot      (ot),
  .raw_any (raw_any),
  .fault   (fault),
  .coast   (coast),
  .status  (status)
);

// File: tb/tb_bridge_fault_monitor.sv
module tb_bridge_fault_monitor;
  logic       clk = 1'b0;
  logic       rst_n, awake, drain_open, uv, ov, ot, ext_low;
  logic [1:0] hi_cmd, lo_cmd, leg_chg, cmp_hi, cmp_lo;
  logic [7:0] dead_len, long_thr;
  logic       fault, coast;
  logic [6:0] status;

  typedef struct {
    string      req;
    logic       f;
    logic       c;
    logic [6:0] s;
  } exp_t;

  exp_t exp_q[$];
  exp_t item;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  bridge_fault_monitor dut (
    .clk(clk), .rst_n(rst_n), .awake(awake), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .leg_chg(leg_chg), .dead_len(dead_len), .long_thr(long_thr),
    .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .drain_open(drain_open),
    .uv(uv), .ov(ov), .ot(ot), .ext_low(ext_low),
    .fault(fault), .coast(coast), .status(status)
  );

  task automatic expect_now(string r, logic f, logic c, logic [6:0] s);
    exp_q.push_back('{r, f, c, s});
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
  endtask

  always @(posedge clk) begin
    #5;
    while (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      checks++;
      if (fault !== item.f || coast !== item.c || status !== item.s) begin
        errors++;
        $display("FAIL %s: fault=%b coast=%b status=%h, expected fault=%b coast=%b status=%h",
                 item.req, fault, coast, status, item.f, item.c, item.s);
      end
    end
  end

  initial begin
    rst_n = 1'b0; awake = 1'b0; hi_cmd = '0; lo_cmd = '0; leg_chg = '0;
    cmp_hi = '0; cmp_lo = '0; drain_open = 1'b0; uv = 1'b0; ov = 1'b0;
    ot = 1'b0; ext_low = 1'b0; dead_len = 8'd4; long_thr = 8'd20;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(1); expect_now("R1 reset", 1'b0, 1'b1, 7'h00);
    @(negedge clk) awake = 1'b1;
    edges(1); expect_now("R9 idle", 1'b0, 1'b0, 7'h00);
    edges(30);

    // R5 and R2: leg A after long idle, one dead time
    @(negedge clk) begin hi_cmd[0] = 1'b1; cmp_hi[0] = 1'b1; leg_chg[0] = 1'b1; end
    @(negedge clk) leg_chg[0] = 1'b0;
    edges(4); expect_now("R5 blank", 1'b0, 1'b0, 7'h00);
    edges(1); expect_now("R2 stg latch", 1'b0, 1'b0, 7'h01);
    edges(2); expect_now("R8 not yet", 1'b0, 1'b0, 7'h01);
    edges(1); expect_now("R9 coast", 1'b1, 1'b1, 7'h01);
    // R6 then R1 clear
    @(negedge clk) cmp_hi[0] = 1'b0;
    edges(3); expect_now("R6 held", 1'b1, 1'b1, 7'h01);
    @(negedge clk) begin awake = 1'b0; hi_cmd[0] = 1'b0; end
    edges(1); expect_now("R1 sleep clear", 1'b1, 1'b1, 7'h00);
    @(negedge clk) awake = 1'b1;
    edges(4); expect_now("R1 cleared", 1'b0, 1'b0, 7'h00);

    // R4 and R3: leg A change while active, two dead times
    @(negedge clk) begin hi_cmd[0] = 1'b1; leg_chg[0] = 1'b1; end
    @(negedge clk) leg_chg[0] = 1'b0;
    edges(5);
    @(negedge clk) begin hi_cmd[0] = 1'b0; lo_cmd[0] = 1'b1; cmp_lo[0] = 1'b1; leg_chg[0] = 1'b1; end
    @(negedge clk) leg_chg[0] = 1'b0;
    edges(8); expect_now("R4 blank", 1'b0, 1'b0, 7'h00);
    edges(1); expect_now("R3 stb latch", 1'b0, 1'b0, 7'h04);
    @(negedge clk) begin awake = 1'b0; lo_cmd[0] = 1'b0; cmp_lo[0] = 1'b0; end
    @(negedge clk) awake = 1'b1;
    edges(6); expect_now("R1 cleared 2", 1'b0, 1'b0, 7'h00);

    // R12: uncommanded switches on leg B
    @(negedge clk) begin cmp_hi[1] = 1'b1; cmp_lo[1] = 1'b1; end
    edges(10); expect_now("R12 ignored", 1'b0, 1'b0, 7'h00);
    @(negedge clk) begin cmp_hi[1] = 1'b0; cmp_lo[1] = 1'b0; end

    // R11: drain open on leg B high side
    @(negedge clk) begin hi_cmd[1] = 1'b1; drain_open = 1'b1; leg_chg[1] = 1'b1; end
    @(negedge clk) leg_chg[1] = 1'b0;
    edges(4); expect_now("R5 blank B", 1'b0, 1'b0, 7'h00);
    edges(1); expect_now("R11 drain open", 1'b0, 1'b0, 7'h02);
    @(negedge clk) begin awake = 1'b0; hi_cmd[1] = 1'b0; drain_open = 1'b0; end
    @(negedge clk) awake = 1'b1;
    edges(6); expect_now("R1 cleared 3", 1'b0, 1'b0, 7'h00);

    // R7 and R8: undervoltage follows cause
    @(negedge clk) uv = 1'b1;
    edges(1); expect_now("R7 uv shown", 1'b0, 1'b0, 7'h10);
    edges(2); expect_now("R8 third sample", 1'b1, 1'b1, 7'h10);
    @(negedge clk) uv = 1'b0;
    edges(1); expect_now("R7 uv gone", 1'b1, 1'b1, 7'h00);
    edges(2); expect_now("R8 fall", 1'b0, 1'b0, 7'h00);

    // R8: two-sample overvoltage glitch
    @(negedge clk) ov = 1'b1;
    @(negedge clk);
    @(negedge clk) ov = 1'b0;
    edges(5); expect_now("R8 glitch", 1'b0, 1'b0, 7'h00);

    // R10: external low disables coast except for thermal
    @(negedge clk) begin ext_low = 1'b1; uv = 1'b1; end
    edges(3); expect_now("R10 no coast", 1'b1, 1'b0, 7'h10);
    @(negedge clk) ot = 1'b1;
    edges(1); expect_now("R10 thermal coast", 1'b1, 1'b1, 7'h50);
    @(negedge clk) begin ot = 1'b0; uv = 1'b0; ext_low = 1'b0; end
    edges(4); expect_now("R7 all clear", 1'b0, 1'b0, 7'h00);

    @(negedge clk) awake = 1'b0;
    edges(1); expect_now("R1 sleep coast", 1'b0, 1'b1, 7'h00);

    edges(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(5000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule